// File: doc/BRIEF.md
# USB device event interrupt unit

This block gathers the bus-level events reported by a USB device protocol front end and turns them into one interrupt request for a CPU. Each event has a sticky flag that a one-cycle strobe from the front end sets, and an enable bit beside it. The interrupt request is raised while any flag has its enable set. Software reads the flags, clears the ones it has handled by writing 0 to them, and programs the enables through an 8-bit register port with one select bit.

Suspend detection is part of the block. A built-in timer counts clock ticks in units of one millisecond while the bus stays idle in the J state. After a configurable number of idle milliseconds (three by default, which is three frame periods) it raises the suspend flag. It raises that flag once for each idle period. The timer starts again whenever the bus leaves J.

Both register views use the same bit layout: bit 6 upstream resume, bit 5 end of resume, bit 4 wake-up, bit 3 end of bus reset, bit 2 start of frame, bit 1 micro start of frame, bit 0 suspend. Bit 7 is reserved.

Top module: `usbdev_evt_irq`

## Requirements
- R1: A one-cycle strobe on an event input sets its flag at that clock edge, at the bit listed above (suspend at bit 0 is set only by the timer). The flag stays set until software clears it.
- R2: A write with `reg_sel`=0 clears each flag whose write-data bit is 0. A flag whose write-data bit is 1 keeps its value, so software can never set a flag.
- R3: If a strobe and a software clear hit the same flag in the same cycle, the flag is set after that edge.
- R4: `irq` is registered. On each edge it takes the OR over all bits of flag AND enable, as those values stood before that edge.
- R5: After reset all flags are 0, `irq` is 0 and the enable register reads 0x08, so only the end-of-reset enable is set.
- R6: Bit 7 of both registers always reads 0, including after a write of 1 to it. A write with `reg_sel`=1 loads enable bits 6..0 from the write data.
- R7: The suspend flag is set on the edge that completes IDLE_MS×TICKS_PER_MS consecutive cycles with `line_idle_j` high, and not before.
- R8: A single cycle with `line_idle_j` low restarts the idle count from zero.
- R9: Within one unbroken idle period the suspend flag is set only once. After software clears it, it stays clear until the bus has left J and stayed idle for a full period again.
- R10: `reg_rdata` is registered. After each edge it shows the register picked by `reg_sel` (0 = flags, 1 = enables) as it stood just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register selected by reg_sel |
| reg_sel | input | 1 | Register select: 0 flags, 1 enables |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| evt_up_resume | input | 1 | Upstream resume strobe |
| evt_resume_end | input | 1 | End-of-resume strobe |
| evt_wakeup | input | 1 | Wake-up strobe |
| evt_reset_end | input | 1 | End-of-bus-reset strobe |
| evt_sof | input | 1 | Start-of-frame strobe |
| evt_msof | input | 1 | Micro-start-of-frame strobe |
| line_idle_j | input | 1 | High while the bus is idle in the J state |
| irq | output | 1 | Combined interrupt request |

## Verification
The collision that matters is a hardware event strobe and a software clear of the flag register in the same cycle. Dropping the event there would lose an interrupt without any trace. The bench raises a start-of-frame strobe in the same cycle as a write of all zeros to the flags. It then reads back the register and expects the start-of-frame flag still set and every other flag clear. A second collision occurs when a read and an event fall in one cycle: the registered read must show the old value first and the new value one cycle later.

// File: rtl/usbdev_evt_pkg.sv
package usbdev_evt_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned NUM_EVT = 7;

  localparam int unsigned EV_SUSPEND    = 0;
  localparam int unsigned EV_MSOF       = 1;
  localparam int unsigned EV_SOF        = 2;
  localparam int unsigned EV_RESET_END  = 3;
  localparam int unsigned EV_WAKEUP     = 4;
  localparam int unsigned EV_RESUME_END = 5;
  localparam int unsigned EV_UP_RESUME  = 6;

  localparam logic [NUM_EVT-1:0] ENABLE_RESET_VAL = NUM_EVT'(1) << EV_RESET_END;

  typedef enum logic {
    SEL_FLAGS  = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/usbdev_evt_flag_bank.sv
module usbdev_evt_flag_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hw_set,
  input  logic         sw_we,
  input  logic [N-1:0] sw_wdata,
  output logic [N-1:0] flag_q
);
  // One sticky flag per event; software may only clear (write 0).
  for (genvar b = 0; b < N; b++) begin : g_flag
    logic clr;
    assign clr = sw_we && !sw_wdata[b];
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[b] <= 1'b0;
      end else if (hw_set[b]) begin
        flag_q[b] <= 1'b1;          // event beats a same-cycle clear
      end else if (clr) begin
        flag_q[b] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usbdev_evt_enable_reg.sv
module usbdev_evt_enable_reg #(
  parameter int unsigned    N       = 7,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= RST_VAL;
    end else if (we) begin
      en_q <= wdata;
    end
  end
endmodule

// File: rtl/usbdev_idle_suspend_timer.sv
module usbdev_idle_suspend_timer #(
  parameter int unsigned TICKS_PER_MS = 48000,
  parameter int unsigned IDLE_MS      = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_idle_j,
  output logic susp_evt
);
  localparam int unsigned PRE_W = $clog2(TICKS_PER_MS + 1);
  localparam int unsigned MS_W  = $clog2(IDLE_MS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MS - 1);
  localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(IDLE_MS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;
  logic             fired_q;
  logic             pre_wrap;
  logic             ms_done;

  assign pre_wrap = (pre_q == PRE_LAST);
  assign ms_done  = (ms_q == MS_LAST);
  assign susp_evt = line_idle_j && !fired_q && pre_wrap && ms_done;

  always_ff @(posedge clk) begin
    if (rst || !line_idle_j) begin
      pre_q   <= '0;
      ms_q    <= '0;
      fired_q <= 1'b0;
    end else if (!fired_q) begin
      if (pre_wrap) begin
        pre_q <= '0;
        if (ms_done) begin
          fired_q <= 1'b1;          // hold until the bus leaves J
        end else begin
          ms_q <= ms_q + MS_W'(1);
        end
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/usbdev_evt_irq.sv
module usbdev_evt_irq
  import usbdev_evt_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 48000,
  parameter int unsigned IDLE_MS      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             evt_up_resume,
  input  logic             evt_resume_end,
  input  logic             evt_wakeup,
  input  logic             evt_reset_end,
  input  logic             evt_sof,
  input  logic             evt_msof,
  input  logic             line_idle_j,
  output logic             irq
);
  logic [NUM_EVT-1:0] hw_set;
  logic [NUM_EVT-1:0] flag_q;
  logic [NUM_EVT-1:0] en_q;
  logic               susp_evt;
  logic               flag_we;
  logic               en_we;

  assign flag_we = reg_wr && (reg_sel_e'(reg_sel) == SEL_FLAGS);
  assign en_we   = reg_wr && (reg_sel_e'(reg_sel) == SEL_ENABLE);

  always_comb begin
    hw_set                = '0;
    hw_set[EV_SUSPEND]    = susp_evt;
    hw_set[EV_MSOF]       = evt_msof;
    hw_set[EV_SOF]        = evt_sof;
    hw_set[EV_RESET_END]  = evt_reset_end;
    hw_set[EV_WAKEUP]     = evt_wakeup;
    hw_set[EV_RESUME_END] = evt_resume_end;
    hw_set[EV_UP_RESUME]  = evt_up_resume;
  end

  usbdev_idle_suspend_timer #(
    .TICKS_PER_MS(TICKS_PER_MS),
    .IDLE_MS     (IDLE_MS)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .line_idle_j(line_idle_j),
    .susp_evt   (susp_evt)
  );

  usbdev_evt_flag_bank #(.N(NUM_EVT)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .hw_set  (hw_set),
    .sw_we   (flag_we),
    .sw_wdata(reg_wdata[NUM_EVT-1:0]),
    .flag_q  (flag_q)
  );

  usbdev_evt_enable_reg #(.N(NUM_EVT), .RST_VAL(ENABLE_RESET_VAL)) u_enable (
    .clk  (clk),
    .rst  (rst),
    .we   (en_we),
    .wdata(reg_wdata[NUM_EVT-1:0]),
    .en_q (en_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq       <= |(flag_q & en_q);
      reg_rdata <= {1'b0, (reg_sel_e'(reg_sel) == SEL_ENABLE) ? en_q : flag_q};
    end
  end
endmodule

// File: rtl/usbdev_evt_irq_chk.sv
module usbdev_evt_irq_chk
  import usbdev_evt_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               reg_wr,
  input logic               reg_sel,
  input logic [REG_W-1:0]   reg_wdata,
  input logic [REG_W-1:0]   reg_rdata,
  input logic               irq,
  input logic               line_idle_j,
  input logic [NUM_EVT-1:0] hw_set,
  input logic [NUM_EVT-1:0] flag_q,
  input logic [NUM_EVT-1:0] en_q,
  input logic               susp_evt
);
  a_r1_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_sel == 1'b0) |=> ((($past(flag_q) & ~flag_q)) == '0));

  a_r2_write_one_keeps: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == 1'b0) |=>
      (($past(flag_q) & $past(reg_wdata[NUM_EVT-1:0]) & ~flag_q) == '0));

  a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|hw_set) |=> ((flag_q & $past(hw_set)) == $past(hw_set)));

  a_r4_irq_combine: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(flag_q & en_q)));

  a_r5_reset_values: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_q == ENABLE_RESET_VAL && flag_q == '0 && !irq));

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata[REG_W-1]);

  a_r7_susp_needs_idle: assert property (@(posedge clk) disable iff (rst)
    susp_evt |-> line_idle_j);

  a_r9_susp_single: assert property (@(posedge clk) disable iff (rst)
    susp_evt |=> !susp_evt);
endmodule

bind usbdev_evt_irq usbdev_evt_irq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_sel    (reg_sel),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .irq        (irq),
  .line_idle_j(line_idle_j),
  .hw_set     (hw_set),
  .flag_q     (flag_q),
  .en_q       (en_q),
  .susp_evt   (susp_evt)
);

// File: tb/usbdev_evt_irq_bench.sv
`timescale 1ns/1ps
module usbdev_evt_irq_bench;
  localparam int unsigned TPM  = 4;
  localparam int unsigned IMS  = 3;
  localparam int unsigned IDLE = TPM * IMS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       evt_up_resume = 0, evt_resume_end = 0, evt_wakeup = 0;
  logic       evt_reset_end = 0, evt_sof = 0, evt_msof = 0;
  logic       line_idle_j = 0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usbdev_evt_irq #(.TICKS_PER_MS(TPM), .IDLE_MS(IMS)) u_usbdev_evt_irq (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_up_resume(evt_up_resume), .evt_resume_end(evt_resume_end),
    .evt_wakeup(evt_wakeup), .evt_reset_end(evt_reset_end),
    .evt_sof(evt_sof), .evt_msof(evt_msof),
    .line_idle_j(line_idle_j), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic set_evt(input int idx, input logic v);
    case (idx)
      1: evt_msof       = v;
      2: evt_sof        = v;
      3: evt_reset_end  = v;
      4: evt_wakeup     = v;
      5: evt_resume_end = v;
      6: evt_up_resume  = v;
      default: ;
    endcase
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); set_evt(idx, 1'b1);
    @(negedge clk); set_evt(idx, 1'b0);
  endtask

  task automatic write_reg(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic sel, output logic [7:0] d);
    @(negedge clk); reg_sel = sel;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic idle_for(input int n);
    @(negedge clk); line_idle_j = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    line_idle_j = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R5 irq after reset", {7'b0, irq}, 8'h00);
    read_reg(1'b0, v); chk("R5 flags after reset", v, 8'h00);
    read_reg(1'b1, v); chk("R5 enables after reset", v, 8'h08);
  endtask

  task automatic t_events;
    logic [7:0] v;
    for (int b = 1; b <= 6; b++) begin
      write_reg(1'b0, 8'h00);
      pulse(b);
      repeat (4) @(negedge clk);
      read_reg(1'b0, v);
      chk($sformatf("R1 sticky flag bit %0d", b), v, 8'(1 << b));
    end
    write_reg(1'b0, 8'h00);
  endtask

  task automatic t_write_one;
    logic [7:0] v;
    pulse(2); pulse(1);
    write_reg(1'b0, 8'hFF);
    read_reg(1'b0, v); chk("R2 write of ones keeps flags", v, 8'h06);
    write_reg(1'b0, 8'hFB);
    read_reg(1'b0, v); chk("R2 write 0 clears only sof", v, 8'h02);
    write_reg(1'b0, 8'h00);
    read_reg(1'b0, v); chk("R2 full clear", v, 8'h00);
  endtask

  task automatic t_set_wins;
    logic [7:0] v;
    pulse(4);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h00; evt_sof = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; evt_sof = 1'b0;
    read_reg(1'b0, v); chk("R3 set beats same-cycle clear", v, 8'h04);
    write_reg(1'b0, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    write_reg(1'b1, 8'h00);
    for (int b = 1; b <= 6; b++) pulse(b);
    @(negedge clk);
    chk("R4 no irq with enables off", {7'b0, irq}, 8'h00);
    write_reg(1'b0, 8'h00);
    write_reg(1'b1, 8'h04);
    pulse(2);
    chk("R4 irq not yet (registered)", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R4 irq on enabled sof", {7'b0, irq}, 8'h01);
    pulse(1);
    write_reg(1'b0, 8'hFB);
    chk("R4 irq one cycle after clear", {7'b0, irq}, 8'h01);
    @(negedge clk);
    chk("R4 irq drops after clear", {7'b0, irq}, 8'h00);
    read_reg(1'b0, v); chk("R4 msof still pending", v, 8'h02);
    write_reg(1'b0, 8'h00);
  endtask

  task automatic t_reserved;
    logic [7:0] v;
    write_reg(1'b1, 8'hFF);
    read_reg(1'b1, v); chk("R6 enable bit7 reads 0", v, 8'h7F);
    pulse(6);
    read_reg(1'b0, v); chk("R6 flag bit7 reads 0", v, 8'h40);
    write_reg(1'b0, 8'h00);
    write_reg(1'b1, 8'h00);
  endtask

  task automatic t_read_latency;
    logic [7:0] v;
    @(negedge clk); reg_sel = 1'b0; evt_wakeup = 1'b1;
    @(negedge clk); evt_wakeup = 1'b0;
    v = reg_rdata; chk("R10 read shows pre-edge value", v, 8'h00);
    @(negedge clk);
    v = reg_rdata; chk("R10 read shows new value next cycle", v, 8'h10);
    write_reg(1'b0, 8'h00);
  endtask

  task automatic t_suspend;
    logic [7:0] v;
    idle_for(IDLE - 1);
    read_reg(1'b0, v); chk("R7 no suspend one cycle short", v, 8'h00);
    idle_for(IDLE);
    read_reg(1'b0, v); chk("R7 suspend after full idle", v, 8'h01);
    write_reg(1'b0, 8'h00);
    idle_for(5);
    idle_for(IDLE - 1);
    read_reg(1'b0, v); chk("R8 count restarts after leaving J", v, 8'h00);
    @(negedge clk); line_idle_j = 1'b1;
    repeat (IDLE + 2) @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h00;
    @(negedge clk); reg_wr = 1'b0;
    repeat (3 * IDLE) @(negedge clk);
    v = reg_rdata; chk("R9 single suspend per idle period", v, 8'h00);
    line_idle_j = 1'b0;
    idle_for(IDLE);
    read_reg(1'b0, v); chk("R9 suspend again after new idle period", v, 8'h01);
    write_reg(1'b0, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_events();
    t_write_one();
    t_set_wins();
    t_irq();
    t_reserved();
    t_read_latency();
    t_suspend();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule